// File: doc/BRIEF.md
# Precise Exception Tracking Unit

This block keeps exceptions in program order for a five-stage in-order pipeline. Each instruction carries a small exception status vector and its PC alongside it through the decode, execute, memory and write-back slots. A stage that sees a fault sets the matching bit in that vector. The vector is read only when the instruction reaches write-back, which is the commit point. Faults detected early therefore never overtake an older instruction whose fault shows up later in time.

When a faulting instruction reaches write-back on a cycle that is not stalled, three things happen. First, the block drives a write-enable kill in that same cycle. Second, it captures the instruction's PC as the restart address, together with the winning cause code. Third, it computes the handler address from a vector-table base plus four times the cause code.

On the next cycle the block pulses flush and drops every tracked instruction. The cycle after that, it pulses redirect so that fetch continues at the handler address. An external interrupt request that is not masked is attached to the oldest instruction in flight and then commits like any other cause.

Top module: `xt_tracker`

## Requirements
- R1: After reset, kill_we, flush and redirect are 0 and epc, cause and handler_pc read 0.
- R2: Cause codes are as follows. Fetch faults use if_fault bit0 = page fault (code 0), bit1 = misaligned (code 1) and bit2 = protection (code 2). An illegal opcode in decode is code 3. An arithmetic fault in execute is code 4. Memory faults use mem_fault bit0 = page fault (code 5), bit1 = misaligned (code 6) and bit2 = protection (code 7). An external interrupt is code 8.
- R3: When one instruction has several causes, the lowest code wins. This gives fetch priority over decode, decode over execute, and execute over memory, and within one stage the lower fault bit wins.
- R4: An instruction enters when if_valid is high on an edge. Each stage's strobe is taken on the edge that moves the instruction out of that stage. kill_we is high during the cycle the instruction sits in write-back, which is four unstalled edges after entry, only if it carries a cause. A clean instruction never raises kill_we.
- R5: An older instruction's fault is taken even when a younger instruction raised a fault in the same cycle or earlier.
- R6: On the commit edge, epc takes the faulting instruction's fetch PC and cause takes its code. Both hold until the next commit.
- R7: handler_pc, updated on the commit edge, equals vec_base + 4*cause.
- R8: flush is high for exactly the one cycle after commit, and redirect for exactly the cycle after that. All younger instructions are discarded, and if_valid is ignored during the flush and redirect cycles.
- R9: While stall is high, nothing advances, no strobe is sampled and kill_we stays 0. A faulting instruction held in write-back commits on the first unstalled cycle.
- R10: An unmasked irq_req sampled on an unstalled edge marks the oldest instruction in flight with code 8. While irq_mask is 1 the request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze the pipeline this cycle |
| if_valid | input | 1 | An instruction is being fetched |
| if_pc | input | PC_W | PC of the fetched instruction |
| if_fault | input | 3 | Fetch faults: page, misaligned, protection |
| id_illegal | input | 1 | Decode found an illegal opcode |
| ex_arith | input | 1 | Execute raised an arithmetic fault |
| mem_fault | input | 3 | Data faults: page, misaligned, protection |
| irq_req | input | 1 | External interrupt request |
| irq_mask | input | 1 | Masks irq_req when 1 |
| vec_base | input | PC_W | Vector-table base address |
| kill_we | output | 1 | Suppress the write-back state update |
| flush | output | 1 | Invalidate all pipeline stages |
| redirect | output | 1 | Fetch from handler_pc |
| epc | output | PC_W | Saved restart PC |
| cause | output | CODE_W | Saved cause code |
| handler_pc | output | PC_W | Handler entry address |

## Verification
A status vector that travels to the wrong slot or loses a bit shows up at the write-back cycle. Either kill_we appears one cycle early or late, or it is missing, or cause names a lower-priority code, and epc and handler_pc are wrong one cycle later. A flush that fails to clear the younger slots shows as a second kill_we within three cycles after redirect. An interrupt attached to the wrong instruction shows as an epc that names the younger PC.

// File: rtl/xt_pkg.sv
package xt_pkg;
   localparam int XT_NSTAGE  = 4;   // ID, EX, MEM, WB slots
   localparam int XT_NCAUSE  = 9;
   localparam int XT_FAULT_W = 3;
   localparam int XT_IF_BASE = 0;
   localparam int XT_ID_BIT  = 3;
   localparam int XT_EX_BIT  = 4;
   localparam int XT_MEM_BASE = 5;
   localparam int XT_IRQ_BIT = 8;
endpackage

// File: rtl/xt_stage.sv
module xt_stage #(
   parameter int PC_W = 32,
   parameter int NC   = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            adv,
   input  logic            in_valid,
   input  logic [NC-1:0]   in_vec,
   input  logic [PC_W-1:0] in_pc,
   output logic            out_valid,
   output logic [NC-1:0]   out_vec,
   output logic [PC_W-1:0] out_pc
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
         out_pc    <= '0;
      end else if (clr) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
      end else if (adv) begin
         out_valid <= in_valid;
         out_vec   <= in_valid ? in_vec : '0;
         out_pc    <= in_pc;
      end
   end
endmodule

// File: rtl/xt_prio_enc.sv
module xt_prio_enc #(
   parameter int N = 9,
   parameter int W = 5
) (
   input  logic [N-1:0] req,
   output logic [W-1:0] code
);
   always_comb begin
      code = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) code = W'(i);
      end
   end
endmodule

// File: rtl/xt_vector.sv
module xt_vector #(
   parameter int PC_W        = 32,
   parameter int CODE_W      = 5,
   parameter int ENTRY_SHIFT = 2,
   parameter bit VEC_OR      = 1'b0
) (
   input  logic [PC_W-1:0]   base,
   input  logic [CODE_W-1:0] code,
   output logic [PC_W-1:0]   addr
);
   logic [PC_W-1:0] offs;
   assign offs = PC_W'(code) << ENTRY_SHIFT;

   generate
      if (VEC_OR) begin : g_or
         assign addr = base | offs;
      end else begin : g_add
         assign addr = base + offs;
      end
   endgenerate
endmodule

// File: rtl/xt_tracker.sv
module xt_tracker
   import xt_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int CODE_W      = 5,
   parameter int ENTRY_SHIFT = 2,
   parameter bit VEC_OR      = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  stall,
   input  logic                  if_valid,
   input  logic [PC_W-1:0]       if_pc,
   input  logic [XT_FAULT_W-1:0] if_fault,
   input  logic                  id_illegal,
   input  logic                  ex_arith,
   input  logic [XT_FAULT_W-1:0] mem_fault,
   input  logic                  irq_req,
   input  logic                  irq_mask,
   input  logic [PC_W-1:0]       vec_base,
   output logic                  kill_we,
   output logic                  flush,
   output logic                  redirect,
   output logic [PC_W-1:0]       epc,
   output logic [CODE_W-1:0]     cause,
   output logic [PC_W-1:0]       handler_pc
);
   localparam int NS = XT_NSTAGE;
   localparam int NC = XT_NCAUSE;

   generate
      if ((2 ** CODE_W) < NC) begin : g_bad_code
         $error("CODE_W too narrow for the cause set");
      end
      if (PC_W < CODE_W + ENTRY_SHIFT) begin : g_bad_pc
         $error("PC_W too narrow for the vector offset");
      end
   endgenerate

   logic [NS-1:0]   sv;
   logic [NC-1:0]   sx  [NS];
   logic [PC_W-1:0] sp  [NS];
   logic [NS-1:0]   iv;
   logic [NC-1:0]   ix  [NS];
   logic [NC-1:0]   ixf [NS];
   logic [PC_W-1:0] ip  [NS];
   logic [NC-1:0]   loc [NS-1];

   logic            flush_q, redir_q, blk, commit, adv, clr, irq_take;
   logic [CODE_W-1:0] win_code;
   logic [PC_W-1:0]   vec_addr;

   assign blk      = flush_q | redir_q;
   assign commit   = sv[NS-1] & (|sx[NS-1]) & ~stall;
   assign adv      = ~stall & ~blk;
   assign clr      = commit | blk;
   assign irq_take = irq_req & ~irq_mask;

   // Causes each stage adds as its instruction leaves it
   always_comb begin
      for (int s = 0; s < NS - 1; s++) loc[s] = '0;
      loc[0][XT_ID_BIT]                     = id_illegal;
      loc[1][XT_EX_BIT]                     = ex_arith;
      loc[2][XT_MEM_BASE +: XT_FAULT_W]     = mem_fault;
   end

   always_comb begin
      iv[0] = if_valid;
      ip[0] = if_pc;
      ix[0] = '0;
      ix[0][XT_IF_BASE +: XT_FAULT_W] = if_fault;
      for (int s = 1; s < NS; s++) begin
         iv[s] = sv[s-1];
         ip[s] = sp[s-1];
         ix[s] = sx[s-1] | (sv[s-1] ? loc[s-1] : '0);
      end
   end

   // Interrupt goes to the oldest instruction after this advance
   always_comb begin
      logic found;
      found = 1'b0;
      for (int s = NS - 1; s >= 0; s--) begin
         ixf[s] = ix[s];
         if (iv[s] && !found) begin
            found = 1'b1;
            if (irq_take) ixf[s][XT_IRQ_BIT] = 1'b1;
         end
      end
   end

   generate
      for (genvar g = 0; g < NS; g++) begin : g_stage
         xt_stage #(.PC_W(PC_W), .NC(NC)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .adv       (adv),
            .in_valid  (iv[g]),
            .in_vec    (ixf[g]),
            .in_pc     (ip[g]),
            .out_valid (sv[g]),
            .out_vec   (sx[g]),
            .out_pc    (sp[g])
         );
      end
   endgenerate

   xt_prio_enc #(.N(NC), .W(CODE_W)) u_prio (
      .req  (sx[NS-1]),
      .code (win_code)
   );

   xt_vector #(
      .PC_W(PC_W), .CODE_W(CODE_W), .ENTRY_SHIFT(ENTRY_SHIFT), .VEC_OR(VEC_OR)
   ) u_vec (
      .base (vec_base),
      .code (win_code),
      .addr (vec_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_q    <= 1'b0;
         redir_q    <= 1'b0;
         epc        <= '0;
         cause      <= '0;
         handler_pc <= '0;
      end else begin
         flush_q <= commit;
         redir_q <= flush_q;
         if (commit) begin
            epc        <= sp[NS-1];
            cause      <= win_code;
            handler_pc <= vec_addr;
         end
      end
   end

   assign kill_we  = commit;
   assign flush    = flush_q;
   assign redirect = redir_q;
endmodule

// File: rtl/xt_tracker_chk.sv
module xt_tracker_chk #(
   parameter int PC_W   = 32,
   parameter int CODE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stall,
   input logic              kill_we,
   input logic              flush,
   input logic              redirect,
   input logic [PC_W-1:0]   epc,
   input logic [CODE_W-1:0] cause
);
   // R8
   kill_then_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_we |=> flush);
   // R8
   flush_then_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (redirect && !flush));
   // R8
   phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({kill_we, flush, redirect}));
   // R9
   stall_no_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !kill_we);
   // R6
   epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !kill_we |=> ($stable(epc) && $stable(cause)));
   // R4
   no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_we |=> !kill_we);
endmodule

bind xt_tracker xt_tracker_chk #(.PC_W(PC_W), .CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .stall(stall), .kill_we(kill_we),
   .flush(flush), .redirect(redirect), .epc(epc), .cause(cause)
);

// File: tb/xt_tracker_tb.sv
module xt_tracker_tb;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, stall, if_valid, id_illegal, ex_arith, irq_req, irq_mask;
   logic [31:0] if_pc, vec_base, epc, handler_pc;
   logic [2:0]  if_fault, mem_fault;
   logic        kill_we, flush, redirect;
   logic [4:0]  cause;

   int errs = 0;
   int checks = 0;

   xt_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .stall(stall), .if_valid(if_valid), .if_pc(if_pc),
      .if_fault(if_fault), .id_illegal(id_illegal), .ex_arith(ex_arith),
      .mem_fault(mem_fault), .irq_req(irq_req), .irq_mask(irq_mask),
      .vec_base(vec_base), .kill_we(kill_we), .flush(flush), .redirect(redirect),
      .epc(epc), .cause(cause), .handler_pc(handler_pc)
   );

   // {if_fault, id_illegal, ex_arith, mem_fault, exp_exc, exp_code}
   localparam logic [13:0] VECS [13] = '{
      {3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 5'd0},
      {3'b001, 1'b0, 1'b0, 3'b000, 1'b1, 5'd0},
      {3'b010, 1'b0, 1'b0, 3'b000, 1'b1, 5'd1},
      {3'b100, 1'b0, 1'b0, 3'b000, 1'b1, 5'd2},
      {3'b110, 1'b0, 1'b0, 3'b000, 1'b1, 5'd1},
      {3'b000, 1'b1, 1'b0, 3'b000, 1'b1, 5'd3},
      {3'b000, 1'b0, 1'b1, 3'b000, 1'b1, 5'd4},
      {3'b000, 1'b0, 1'b0, 3'b001, 1'b1, 5'd5},
      {3'b000, 1'b0, 1'b0, 3'b010, 1'b1, 5'd6},
      {3'b000, 1'b0, 1'b0, 3'b100, 1'b1, 5'd7},
      {3'b100, 1'b1, 1'b1, 3'b111, 1'b1, 5'd2},
      {3'b000, 1'b1, 1'b1, 3'b111, 1'b1, 5'd3},
      {3'b000, 1'b0, 1'b1, 3'b010, 1'b1, 5'd4}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic clear_in;
      stall = 0; if_valid = 0; if_fault = 0; id_illegal = 0;
      ex_arith = 0; mem_fault = 0; irq_req = 0;
   endtask

   task automatic count_kills(input int n, output int k);
      k = 0;
      for (int i = 0; i < n; i++) begin
         tick; #1;
         if (kill_we) k++;
      end
   endtask

   initial begin
      #400000;
      errs++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int k;
      rst_n = 0; irq_mask = 0; if_pc = 0; vec_base = 32'h8000_0000;
      clear_in;
      tick; tick; #1;
      chk("R1 kill_we", kill_we, 0);
      chk("R1 flush", flush, 0);
      chk("R1 redirect", redirect, 0);
      chk("R1 epc", epc, 0);
      chk("R1 cause", cause, 0);
      chk("R1 handler_pc", handler_pc, 0);
      rst_n = 1;
      tick;

      // Table: one instruction per entry, R2/R3/R4/R6/R7/R8
      for (int i = 0; i < 13; i++) begin
         logic [13:0] v;
         logic [31:0] pc;
         v  = VECS[i];
         pc = 32'h0000_1000 + 32'(i) * 16;
         tick;
         if_valid = 1; if_pc = pc; if_fault = v[13:11];
         tick;
         if_valid = 0; if_fault = 0; id_illegal = v[10];
         tick;
         id_illegal = 0; ex_arith = v[9];
         tick;
         ex_arith = 0; mem_fault = v[8:6];
         tick;
         mem_fault = 0; #1;
         chk("R4 kill_we at write-back", kill_we, v[5]);
         tick;
         chk("R8 flush after commit", flush, v[5]);
         if (v[5]) begin
            chk("R2/R3 cause", cause, v[4:0]);
            chk("R6 epc", epc, pc);
            chk("R7 handler_pc", handler_pc, vec_base + 4 * v[4:0]);
         end
         tick;
         chk("R8 redirect", redirect, v[5]);
         chk("R8 flush one cycle", flush, 0);
         tick; tick;
      end

      // R5: older MEM fault beats younger IF fault in the same cycle
      tick;
      if_valid = 1; if_pc = 32'h2000;
      tick;
      if_valid = 0; tick; tick;
      mem_fault = 3'b001; if_valid = 1; if_pc = 32'h2004; if_fault = 3'b001;
      tick;
      clear_in; #1;
      chk("R5 kill_we", kill_we, 1);
      tick;
      chk("R5 cause", cause, 5);
      chk("R5 epc", epc, 32'h2000);
      count_kills(8, k);
      chk("R8 younger discarded", k, 0);
      chk("R6 cause held", cause, 5);

      // R8: fetch ignored during flush and redirect
      tick;
      if_valid = 1; if_pc = 32'h3000; if_fault = 3'b100;
      tick;
      if_valid = 0; if_fault = 0; tick; tick; tick; #1;
      chk("R4 kill_we", kill_we, 1);
      tick;
      if_valid = 1; if_pc = 32'h3100; if_fault = 3'b001;
      chk("R8 flush", flush, 1);
      tick;
      chk("R8 redirect", redirect, 1);
      tick;
      clear_in;
      count_kills(6, k);
      chk("R8 fetch ignored in flush/redirect", k, 0);
      chk("R6 epc held", epc, 32'h3000);

      // R9: stall holds a faulting instruction in write-back
      tick;
      if_valid = 1; if_pc = 32'h4000;
      tick;
      if_valid = 0; id_illegal = 1;
      tick;
      id_illegal = 0; tick; tick;
      stall = 1; #1;
      chk("R9 no kill while stalled", kill_we, 0);
      tick; #1;
      chk("R9 still no kill", kill_we, 0);
      chk("R9 no flush", flush, 0);
      stall = 0; #1;
      chk("R9 commit after release", kill_we, 1);
      tick;
      chk("R9 epc", epc, 32'h4000);
      chk("R9 cause", cause, 3);
      tick; tick; tick;

      // R9: strobe during stall is not sampled
      tick;
      if_valid = 1; if_pc = 32'h4100;
      tick;
      if_valid = 0; tick; tick;
      stall = 1; mem_fault = 3'b001;
      tick;
      stall = 0; mem_fault = 0;
      tick; #1;
      chk("R9 stalled strobe dropped", kill_we, 0);
      tick; tick;

      // R10: interrupt attaches to the oldest instruction
      tick;
      if_valid = 1; if_pc = 32'h5000;
      tick;
      if_pc = 32'h5004;
      tick;
      if_valid = 0; irq_req = 1;
      tick;
      irq_req = 0;
      tick; #1;
      chk("R10 kill_we", kill_we, 1);
      tick;
      chk("R10 cause", cause, 8);
      chk("R10 epc oldest", epc, 32'h5000);
      chk("R7 handler_pc", handler_pc, 32'h8000_0020);
      count_kills(8, k);
      chk("R10 younger not marked", k, 0);

      // R10: masked interrupt has no effect
      irq_mask = 1;
      tick;
      if_valid = 1; if_pc = 32'h6000;
      tick;
      if_pc = 32'h6004;
      tick;
      if_valid = 0; irq_req = 1;
      tick;
      irq_req = 0;
      count_kills(8, k);
      chk("R10 masked no kill", k, 0);
      chk("R10 epc unchanged", epc, 32'h5000);

      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule